// File: doc/BRIEF.md
# GPIO Pin Bank Controller

This block controls a bank of general-purpose pins through a small word-addressed register bus. Every per-pin attribute is changed through a pair of write-one-to-set and write-one-to-clear addresses, and read back at a third, status address. Software can therefore change any group of pins in one write, with no read-modify-write and no race against other code that touches other pins. The attributes are: ownership (pin controller or peripheral), output enable, output data, pull-up, pull-down and open-drain drive.

A pin handed to a peripheral takes its output value and output enable from one of four peripheral functions. Two plain read/write bit-planes choose the function for each pin. The open-drain setting applies to both kinds of pin. The pad level is brought in through a two-flop synchronizer and can always be read back, whoever owns the pin.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every pin is controller-owned, output disabled, output data 0, pull-up on, pull-down off, open-drain off, and function plane bits 0. So pad_oe=0, pad_out=0, pad_pu=all ones and pad_pd=0.
- R2: A write to OWN_SET (address 0) makes the pins set in wdata controller-owned, and OWN_CLR (1) hands them to a peripheral. OWN_STAT (2) reads 1 for each controller-owned pin.
- R3: Output data changes only through DAT_SET (6) and DAT_CLR (7), and DAT_STAT (8) reads it back. Bits written as 0 leave their pins unchanged. Any register write is visible at the outputs right after the clock edge that accepts it.
- R4: OE_SET (3) and OE_CLR (4) switch the output enable, and OE_STAT (5) reads 1 for each driving pin. A controller-owned pin with open-drain off shows its enable on pad_oe and its data on pad_out.
- R5: PU_SET (9), PU_CLR (10) and PU_STAT (11) control the pull-up, and PD_SET (12), PD_CLR (13) and PD_STAT (14) control the pull-down. A PD_SET write also clears the pull-up of the same pins. The results appear on pad_pu and pad_pd.
- R6: MD_SET (15), MD_CLR (16) and MD_STAT (17) control open-drain. On an open-drain pin, pad_out is always 0, and a drive value of 1 releases pad_oe.
- R7: FSEL0 (18) and FSEL1 (19) are read/write planes. A pin that is not controller-owned takes function f={FSEL1 bit, FSEL0 bit}: pad_out from per_out[f*32+pin] and pad_oe from per_oe[f*32+pin], then open-drain is applied.
- R8: LEVEL (20) returns pad_in after a two-flop synchronizer, for controller-owned and peripheral-owned pins alike.
- R9: rdata is registered and shows the value the cycle after rd_en. It is 0 for the write-only addresses (0, 1, 3, 4, 6, 7, 9, 10, 12, 13, 15, 16), for the unmapped addresses 21 to 31, and in any cycle after one without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data, one bit per pin |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pull-up enables |
| pad_pd | output | 32 | Pull-down enables |
| per_out | input | 128 | Peripheral output values, function f in bits f*32 upward |
| per_oe | input | 128 | Peripheral output enables, same layout |

## Verification
The assertions check the following on every cycle:
- a set write forces exactly its mask bits and a clear write touches no other bit;
- PD_SET always leaves the pull-up of its pins off;
- an open-drain pin never drives high;
- idle cycles and write-only or unmapped reads return zero.

Only the bench scenarios can show the other behaviours:
- the peripheral routing for each of the four functions;
- the synchronizer latency on LEVEL;
- the complete reset state;
- the walking-one ownership sweep against a computed model.

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NPIN-1:0]     pad_in,
  output logic [NPIN-1:0]     pad_out,
  output logic [NPIN-1:0]     pad_oe,
  output logic [NPIN-1:0]     pad_pu,
  output logic [NPIN-1:0]     pad_pd,
  input  logic [4*NPIN-1:0]   per_out,
  input  logic [4*NPIN-1:0]   per_oe
);

  localparam logic [ADDR_W-1:0] A_OWN_SET  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OWN_CLR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OWN_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OE_SET   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OE_CLR   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OE_STAT  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DAT_SET  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_DAT_CLR  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_DAT_STAT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PU_SET   = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_PU_CLR   = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_PU_STAT  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_PD_SET   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_PD_CLR   = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_PD_STAT  = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_MD_SET   = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_MD_CLR   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_MD_STAT  = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_FSEL0    = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] A_FSEL1    = ADDR_W'(19);
  localparam logic [ADDR_W-1:0] A_LEVEL    = ADDR_W'(20);

  logic [NPIN-1:0] own_q, oe_q, dat_q, pu_q, pd_q, md_q, sel0_q, sel1_q;
  logic [NPIN-1:0] sync1_q, level_q;
  logic [NPIN-1:0] wm;
  logic [31:0]     rd_val;

  assign wm = wdata[NPIN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '1;
      oe_q   <= '0;
      dat_q  <= '0;
      pu_q   <= '1;
      pd_q   <= '0;
      md_q   <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_OWN_SET: own_q  <= own_q | wm;
        A_OWN_CLR: own_q  <= own_q & ~wm;
        A_OE_SET:  oe_q   <= oe_q | wm;
        A_OE_CLR:  oe_q   <= oe_q & ~wm;
        A_DAT_SET: dat_q  <= dat_q | wm;
        A_DAT_CLR: dat_q  <= dat_q & ~wm;
        A_PU_SET:  pu_q   <= pu_q | wm;
        A_PU_CLR:  pu_q   <= pu_q & ~wm;
        A_PD_SET: begin
          pd_q <= pd_q | wm;
          pu_q <= pu_q & ~wm;
        end
        A_PD_CLR:  pd_q   <= pd_q & ~wm;
        A_MD_SET:  md_q   <= md_q | wm;
        A_MD_CLR:  md_q   <= md_q & ~wm;
        A_FSEL0:   sel0_q <= wm;
        A_FSEL1:   sel1_q <= wm;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      level_q <= '0;
    end else begin
      sync1_q <= pad_in;
      level_q <= sync1_q;
    end
  end

  always_comb begin
    case (addr)
      A_OWN_STAT: rd_val = 32'(own_q);
      A_OE_STAT:  rd_val = 32'(oe_q);
      A_DAT_STAT: rd_val = 32'(dat_q);
      A_PU_STAT:  rd_val = 32'(pu_q);
      A_PD_STAT:  rd_val = 32'(pd_q);
      A_MD_STAT:  rd_val = 32'(md_q);
      A_FSEL0:    rd_val = 32'(sel0_q);
      A_FSEL1:    rd_val = 32'(sel1_q);
      A_LEVEL:    rd_val = 32'(level_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_val : '0;
  end

  assign pad_pu = pu_q;
  assign pad_pd = pd_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [3:0] f_out, f_oe;
    logic [1:0] fs;
    logic       drv, en;
    assign f_out = {per_out[3*NPIN+i], per_out[2*NPIN+i], per_out[NPIN+i], per_out[i]};
    assign f_oe  = {per_oe[3*NPIN+i], per_oe[2*NPIN+i], per_oe[NPIN+i], per_oe[i]};
    assign fs    = {sel1_q[i], sel0_q[i]};
    assign drv   = own_q[i] ? dat_q[i] : f_out[fs];
    assign en    = own_q[i] ? oe_q[i]  : f_oe[fs];
    assign pad_out[i] = drv & ~md_q[i];
    assign pad_oe[i]  = en & ~(md_q[i] & drv);
  end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_pu,
  input logic [NPIN-1:0]   pad_pd,
  input logic [NPIN-1:0]   own_q,
  input logic [NPIN-1:0]   dat_q,
  input logic [NPIN-1:0]   md_q
);

  logic [NPIN-1:0] wmask;
  logic            wo_addr;
  assign wmask   = wdata[NPIN-1:0];
  assign wo_addr = ((int'(addr) < 18) && (int'(addr) % 3 != 2)) || (int'(addr) > 20);

  assert_dat_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 6) |=> ((dat_q & $past(wmask)) == $past(wmask)))
    else $error("data set bits not forced");

  assert_dat_clr_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 7) |=> ((dat_q | $past(wmask)) == ($past(dat_q) | $past(wmask))))
    else $error("data clear touched other bits");

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(own_q) && $stable(dat_q) && $stable(pad_pu)))
    else $error("state changed without write");

  assert_pd_drops_pu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 12) |=> (((pad_pu & $past(wmask)) == '0) && ((pad_pd & $past(wmask)) == $past(wmask))))
    else $error("pull-down set left pull-up on");

  assert_md_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((md_q & pad_out) == '0) && ((own_q & md_q & dat_q & pad_oe) == '0))
    else $error("open-drain pin driving high");

  assert_wo_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wo_addr) |=> (rdata == '0))
    else $error("write-only or unmapped read not zero");

  assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0))
    else $error("rdata nonzero without read");

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .own_q(own_q), .dat_q(dat_q), .md_q(md_q)
);

// File: tb/sim_pinbank_ctrl.sv
`timescale 1ns/1ps
module sim_pinbank_ctrl;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [4*N-1:0] per_out = '0, per_oe = '0;

  logic [N-1:0] m_own, m_oe, m_dat, m_pu, m_pd, m_md, m_s0, m_s1;
  int total = 0, bad = 0;
  bit ended = 0;

  pinbank_ctrl #(.NPIN(N), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .per_out(per_out), .per_oe(per_oe)
  );

  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    case (a)
      0: m_own |= d;   1: m_own &= ~d;
      3: m_oe  |= d;   4: m_oe  &= ~d;
      6: m_dat |= d;   7: m_dat &= ~d;
      9: m_pu  |= d;   10: m_pu &= ~d;
      12: begin m_pd |= d; m_pu &= ~d; end
      13: m_pd &= ~d;
      15: m_md |= d;   16: m_md &= ~d;
      18: m_s0 = d;    19: m_s1 = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, $sformatf("read addr %0d", a), rdata, exp);
  endtask

  task automatic pads_chk(string req);
    logic [N-1:0] eo, ee;
    for (int i = 0; i < N; i++) begin
      int f;
      logic ro, re;
      f  = 2 * int'(m_s1[i]) + int'(m_s0[i]);
      ro = m_own[i] ? m_dat[i] : per_out[f*N+i];
      re = m_own[i] ? m_oe[i]  : per_oe[f*N+i];
      eo[i] = ro & ~m_md[i];
      ee[i] = re & ~(m_md[i] & ro);
    end
    chk(req, "pad_out", pad_out, eo);
    chk(req, "pad_oe", pad_oe, ee);
    chk(req, "pad_pu", pad_pu, m_pu);
    chk(req, "pad_pd", pad_pd, m_pd);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    m_own = '1; m_oe = '0; m_dat = '0; m_pu = '1; m_pd = '0; m_md = '0; m_s0 = '0; m_s1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    pads_chk("R1");
    rd_chk("R1", 2, '1);
    rd_chk("R1", 5, '0);
    rd_chk("R1", 8, '0);
    rd_chk("R1", 11, '1);
    rd_chk("R1", 14, '0);
    rd_chk("R1", 17, '0);
    rd_chk("R1", 18, '0);
    rd_chk("R1", 19, '0);

    // R3 and R4 data and enable patterns on controller-owned pins
    wr(3, 32'hFFFF_0000);
    pads_chk("R4");
    rd_chk("R4", 5, m_oe);
    wr(6, 32'hA5A5_A5A5);
    pads_chk("R3");
    wr(7, 32'h0F0F_0000);
    pads_chk("R3");
    rd_chk("R3", 8, m_dat);
    wr(6, 32'h0000_0000);
    rd_chk("R3", 8, 32'hA0A0_A5A5);
    wr(3, 32'h0000_FFFF);
    wr(4, 32'h00FF_00FF);
    pads_chk("R4");
    rd_chk("R4", 5, 32'hFF00_FF00);

    // R2 walking-one ownership sweep
    for (int i = 0; i < N; i++) begin
      wr(1, 32'h1 << i);
      rd_chk("R2", 2, m_own);
    end
    pads_chk("R2");
    for (int i = 0; i < N; i += 3) begin
      wr(0, 32'h1 << i);
      rd_chk("R2", 2, m_own);
    end
    pads_chk("R2");
    wr(0, '1);

    // R5 pulls
    wr(10, 32'h0000_FFFF);
    pads_chk("R5");
    wr(12, 32'h00FF_00F0);
    pads_chk("R5");
    rd_chk("R5", 11, m_pu);
    rd_chk("R5", 14, 32'h00FF_00F0);
    wr(9, 32'h0000_000F);
    wr(13, 32'h0000_00F0);
    pads_chk("R5");
    rd_chk("R5", 14, m_pd);

    // R6 open-drain
    wr(3, '1);
    wr(15, 32'hF0F0_F0F0);
    pads_chk("R6");
    rd_chk("R6", 17, 32'hF0F0_F0F0);
    wr(6, 32'hFFFF_0000);
    pads_chk("R6");
    wr(7, 32'h3333_3333);
    pads_chk("R6");
    wr(16, 32'hF000_0000);
    pads_chk("R6");

    // R7 function select sweep on peripheral-owned pins
    wr(1, '1);
    for (int f = 0; f < 4; f++) begin
      logic [31:0] p0, p1;
      for (int i = 0; i < N; i++) begin
        p0[i] = 1'(((i + f) >> 0) & 1);
        p1[i] = 1'(((i + f) >> 1) & 1);
      end
      for (int k = 0; k < 4; k++) begin
        per_out[k*N +: N] = {32'h1357_9BDF} ^ (32'h0101_0101 << (k + f));
        per_oe[k*N +: N]  = 32'hC3A5_5A3C ^ (32'h1111_1111 << k) ^ (32'(f) << 8);
      end
      wr(18, p0);
      wr(19, p1);
      rd_chk("R7", 18, p0);
      rd_chk("R7", 19, p1);
      pads_chk("R7");
      wr(16, '1);
      pads_chk("R7");
      wr(15, 32'h0F0F_0F0F);
    end
    wr(0, 32'h0000_FFFF);
    pads_chk("R7");

    // R8 level sampling, both ownerships present
    foreach (pad_in[i]) ;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      pad_in = 32'h8421_1248 ^ (32'hFFFF_0000 >> (t * 8)) ^ 32'(t);
      repeat (2) @(negedge clk);
      rd_chk("R8", 20, pad_in);
    end
    @(negedge clk);
    pad_in = ~pad_in;
    rd_chk("R8", 20, ~pad_in);

    // R9 write-only and unmapped reads
    for (int a = 0; a < 32; a++) begin
      if ((a < 18 && a % 3 != 2) || a > 20) rd_chk("R9", a, '0);
    end
    @(negedge clk);
    chk("R9", "idle rdata", rdata, '0);

    finish_run();
  end
endmodule